// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block keeps the programming word of a frequency synthesizer: a 9-bit feedback divide value (M) and a one-bit output divide select (N). Two paths can write the word. The parallel path uses a 9-bit bus and an active-low strobe. While the strobe is low, the bus flows through to M. When the strobe rises, M stays at the value it held last. The serial path uses a three-wire port. A serial clock shifts data into a 10-bit register, and a load line moves that register into M and N. The load line can also be held high so that every shift updates M and N at once.

All inputs are asynchronous to the block. Each one passes through a two-stage synchronizer into a fast system clock, and edges are found in that domain. The serial clock period must be at least four system clock periods. The block drives M, N, a divide ratio of 2 or 4, a divider-reset output that follows the master reset input, and a flag that marks M values a 16 MHz reference cannot lock to.

Top module: `divcfg_load`

## Requirements
- R1: While `par_ld_n` is low, `m_out` follows `par_m`.
- R2: When `par_ld_n` rises, `m_out` keeps its last value. Later changes on `par_m` have no effect until the strobe goes low again or a serial transfer happens.
- R3: A parallel write forces `n_sel` to 0.
- R4: The shift register moves one place on each rising `ser_clk` edge, but only while `par_ld_n` is high. It keeps the last 10 bits. The first of those 10 bits is N, followed by M bit 8 down to M bit 0. Any earlier (null) bits are dropped.
- R5: A rising edge on `ser_ld` copies the shift register into N and M.
- R6: While `ser_ld` stays high, each shift also copies the new shift register contents into N and M.
- R7: Once `ser_ld` is low, further serial clocks leave `m_out` and `n_sel` unchanged.
- R8: A serial transfer replaces a value that the parallel path has latched.
- R9: `div_ratio` is 2 when `n_sel` is 0 and 4 when `n_sel` is 1.
- R10: `div_rst` copies `mreset` two system clocks later. Master reset leaves `m_out` and `n_sel` unchanged.
- R11: After `rst_n` is released, `m_out` is 0 and `n_sel` is 0.
- R12: `m_oor` is 1 exactly when `m_out` is below 125 or above 350.
- R13: An input change made between clock edges shows on `m_out` after the third rising system clock edge that follows it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_ld_n | input | 1 | Parallel strobe, active low |
| par_m | input | 9 | Parallel M value |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial transfer line |
| mreset | input | 1 | Master reset request |
| m_out | output | 9 | Feedback divide value M |
| n_sel | output | 1 | Output divide select N |
| div_ratio | output | 3 | Output divide ratio, 2 or 4 |
| div_rst | output | 1 | Divider reset |
| m_oor | output | 1 | M outside the lock range |

## Verification
The bound checker checks these rules on every cycle: the parallel path flows through while its strobe is low, the word stays frozen while the strobe is high and `ser_ld` is low, the shift register does not move while the strobe is low, the divider reset has its two-cycle delay, and the ratio output always holds a legal value. Other behaviours depend on the order of events across many serial clocks, and only the bench scenarios show them. These are: how bits are placed inside a frame, that leading null bits are dropped, that a serial transfer replaces a parallel value, that each bit updates the word while `ser_ld` is held high, and that master reset leaves the word unchanged.

// File: rtl/divcfg_pkg.sv
// Shared constants and the programming word type for the divider loader.
// Assumes a 9-bit feedback value and a one-bit output select.
package divcfg_pkg;
    localparam int M_W      = 9;
    localparam int FRAME_W  = M_W + 1;
    localparam int RATIO_W  = 3;
    localparam int DIV_LO   = 2;
    localparam int DIV_HI   = 4;

    typedef struct packed {
        logic           n;
        logic [M_W-1:0] m;
    } cfg_t;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_PAR  = 2'd1,
        SRC_SER  = 2'd2
    } src_e;
endpackage

// File: rtl/divcfg_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is sampled on its own; reset loads RST_VAL into every stage.
module divcfg_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Move input bits through the chain of stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/divcfg_shift.sv
// Serial shift register of the loader. Finds rising serial clock edges and
// shifts in one data bit on each edge while enabled. Only the last FW bits are kept.
// Assumes synchronized inputs and a serial clock of at most a quarter of clk.
module divcfg_shift #(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sdat_s,
    input  logic          enable,
    output logic          shift_pulse,
    output logic [FW-1:0] sh_q,
    output logic [FW-1:0] sh_next
);
    logic sclk_q;

    // Remember the previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Qualify a rising serial clock edge with the enable
    assign shift_pulse = sclk_s & ~sclk_q & enable;

    // Next shift register contents: newest bit goes in at the bottom
    always_comb begin
        sh_next = sh_q;
        if (shift_pulse) sh_next = {sh_q[FW-2:0], sdat_s};
    end

    // Store the shift register
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_next;
    end
endmodule

// File: rtl/divcfg_regs.sv
// Programming word register. Decides which source writes M and N:
// parallel flow-through, a serial transfer, or hold.
// Assumes synchronized controls and a shift value that already includes this cycle's shift.
module divcfg_regs
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_n_s,
    input  logic [M_W-1:0]     par_m_s,
    input  logic               ld_s,
    input  logic               shift_pulse,
    input  logic [FRAME_W-1:0] sh_next,
    output cfg_t               cfg_q
);
    logic ld_q;
    logic ld_rise;
    src_e src;

    // Remember the previous load level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= 1'b0;
        else        ld_q <= ld_s;
    end

    assign ld_rise = ld_s & ~ld_q;

    // Choose the writer: the parallel strobe wins, then serial events
    always_comb begin
        if (!par_n_s)                            src = SRC_PAR;
        else if (ld_rise || (ld_s && shift_pulse)) src = SRC_SER;
        else                                     src = SRC_HOLD;
    end

    // Update the programming word from the chosen source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            case (src)
                SRC_PAR: cfg_q <= '{n: 1'b0, m: par_m_s};
                SRC_SER: cfg_q <= cfg_t'(sh_next);
                default: cfg_q <= cfg_q;
            endcase
        end
    end
endmodule

// File: rtl/divcfg_load.sv
// Top level of the divider configuration loader. Synchronizes the pins,
// runs the serial shifter and the word register, and drives the divider controls
// and the lock range flag.
// Assumes clk runs at least four times faster than ser_clk.
module divcfg_load
    import divcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_LO     = 125,
    parameter int LOCK_HI     = 350
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_ld_n,
    input  logic [M_W-1:0]     par_m,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_ld,
    input  logic               mreset,
    output logic [M_W-1:0]     m_out,
    output logic               n_sel,
    output logic [RATIO_W-1:0] div_ratio,
    output logic               div_rst,
    output logic               m_oor
);
    localparam int CTL_W = 5;
    localparam logic [CTL_W-1:0] CTL_RST = 5'b10000;

    logic [CTL_W-1:0]   ctl_s;
    logic               par_n_s;
    logic               sclk_s;
    logic               sdat_s;
    logic               ser_ld_s;
    logic               mrst_s;
    logic [M_W-1:0]     par_m_s;
    logic               shift_pulse;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] sh_next;
    cfg_t               cfg_q;

    divcfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({par_ld_n, ser_clk, ser_dat, ser_ld, mreset}),
        .q     (ctl_s)
    );

    divcfg_sync #(.W(M_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (par_m),
        .q     (par_m_s)
    );

    assign {par_n_s, sclk_s, sdat_s, ser_ld_s, mrst_s} = ctl_s;

    divcfg_shift #(.FW(FRAME_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .sdat_s      (sdat_s),
        .enable      (par_n_s),
        .shift_pulse (shift_pulse),
        .sh_q        (sh_q),
        .sh_next     (sh_next)
    );

    divcfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .par_n_s     (par_n_s),
        .par_m_s     (par_m_s),
        .ld_s        (ser_ld_s),
        .shift_pulse (shift_pulse),
        .sh_next     (sh_next),
        .cfg_q       (cfg_q)
    );

    assign m_out     = cfg_q.m;
    assign n_sel     = cfg_q.n;
    assign div_ratio = cfg_q.n ? RATIO_W'(DIV_HI) : RATIO_W'(DIV_LO);
    assign div_rst   = mrst_s;
    assign m_oor     = (cfg_q.m < M_W'(LOCK_LO)) || (cfg_q.m > M_W'(LOCK_HI));
endmodule

// File: rtl/divcfg_chk.sv
// Property checker for the divider configuration loader, bound to the top.
// Assumes the internal synchronized controls are visible by name in the top.
module divcfg_chk
    import divcfg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               mreset,
    input logic               par_n_s,
    input logic               ser_ld_s,
    input logic [M_W-1:0]     par_m_s,
    input logic [FRAME_W-1:0] sh_q,
    input logic [M_W-1:0]     m_out,
    input logic               n_sel,
    input logic [RATIO_W-1:0] div_ratio,
    input logic               div_rst,
    input logic               m_oor
);
    logic [1:0] cyc;

    // Count cycles since reset, stopping at three
    always_ff @(posedge clk) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    p_par_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !par_n_s |=> (m_out == $past(par_m_s)) && !n_sel);

    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_n_s && !ser_ld_s) |=> $stable({n_sel, m_out}));

    p_shift_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !par_n_s |=> $stable(sh_q));

    p_ratio_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(div_ratio) == 1) && !div_ratio[0] && (div_ratio <= RATIO_W'(DIV_HI)));

    p_mr_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (div_rst == $past(mreset, 2)));

    p_flag_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(m_out) |-> $stable(m_oor));
endmodule

bind divcfg_load divcfg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mreset    (mreset),
    .par_n_s   (par_n_s),
    .ser_ld_s  (ser_ld_s),
    .par_m_s   (par_m_s),
    .sh_q      (sh_q),
    .m_out     (m_out),
    .n_sel     (n_sel),
    .div_ratio (div_ratio),
    .div_rst   (div_rst),
    .m_oor     (m_oor)
);

// File: tb/sim_divcfg_load.sv
`timescale 1ns/1ps
module sim_divcfg_load;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       par_ld_n;
    logic [8:0] par_m;
    logic       ser_clk;
    logic       ser_dat;
    logic       ser_ld;
    logic       mreset;
    logic [8:0] m_out;
    logic       n_sel;
    logic [2:0] div_ratio;
    logic       div_rst;
    logic       m_oor;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Vector: {serial?, null count, N bit, M value}
    localparam int NV = 8;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 2'd0, 1'b0, 9'd125},
        {1'b1, 2'd3, 1'b1, 9'd350},
        {1'b0, 2'd0, 1'b1, 9'd351},
        {1'b1, 2'd0, 1'b0, 9'd124},
        {1'b1, 2'd2, 1'b1, 9'd511},
        {1'b0, 2'd0, 1'b0, 9'd341},
        {1'b1, 2'd1, 1'b0, 9'd170},
        {1'b1, 2'd3, 1'b1, 9'd200}
    };

    always #10 clk = ~clk;

    divcfg_load u0 (
        .clk(clk), .rst_n(rst_n), .par_ld_n(par_ld_n), .par_m(par_m),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld), .mreset(mreset),
        .m_out(m_out), .n_sel(n_sel), .div_ratio(div_ratio),
        .div_rst(div_rst), .m_oor(m_oor)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_word(input string tag, input int em, input int en);
        chk({tag, " m"}, m_out, em);
        chk({tag, " n"}, n_sel, en);
        chk({tag, " ratio R9"}, div_ratio, en ? 4 : 2);
        chk({tag, " flag R12"}, m_oor, (em < 125 || em > 350) ? 1 : 0);
    endtask

    task automatic sbit(input logic b);
        ser_dat = b;
        step(2);
        ser_clk = 1'b1;
        step(4);
        ser_clk = 1'b0;
        step(2);
    endtask

    task automatic send_bits(input logic [9:0] w);
        for (int b = 9; b >= 0; b--) sbit(w[b]);
    endtask

    task automatic pulse_ld();
        ser_ld = 1'b1;
        step(6);
        ser_ld = 1'b0;
        step(6);
    endtask

    task automatic par_write(input logic [8:0] v);
        par_m    = v;
        par_ld_n = 1'b0;
        step(6);
        par_ld_n = 1'b1;
        step(6);
    endtask

    initial begin
        rst_n = 1'b0; par_ld_n = 1'b1; par_m = '0;
        ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0; mreset = 1'b0;
        step(5);
        rst_n = 1'b1;
        step(1);
        // R11: reset values
        chk_word("R11 reset", 0, 0);
        chk("R11 div_rst", div_rst, 0);

        // R13: three-edge latency of the parallel path
        par_m = 9'd300; par_ld_n = 1'b0;
        step(2);
        chk("R13 before third edge", m_out, 0);
        step(1);
        chk("R13 after third edge", m_out, 300);
        par_ld_n = 1'b1;
        step(6);

        // R2: bus changes after the strobe rises are ignored
        par_m = 9'd17;
        step(8);
        chk("R2 hold", m_out, 300);

        // R1: flow-through while the strobe is low
        par_ld_n = 1'b0; par_m = 9'd10;
        step(5);
        chk("R1 follow a", m_out, 10);
        par_m = 9'd20;
        step(5);
        chk("R1 follow b", m_out, 20);
        par_ld_n = 1'b1;
        step(3);
        par_m = 9'd5;
        step(6);
        chk("R2 captured", m_out, 20);

        // Table: R3 R5 R8 with null bits (R4), ratio and flag
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) begin
                for (int k = 0; k < int'(VEC[i][11:10]); k++) sbit(k[0]);
                send_bits(VEC[i][9:0]);
                pulse_ld();
                chk_word($sformatf("R5 R8 R4 vec%0d", i), VEC[i][8:0], VEC[i][9]);
            end else begin
                par_write(VEC[i][8:0]);
                chk_word($sformatf("R3 vec%0d", i), VEC[i][8:0], 0);
            end
        end

        // R6: load held high, each shift updates the word
        ser_ld = 1'b1;
        step(6);
        chk_word("R5 ld rise", 200, 1);
        sbit(1'b0);
        chk_word("R6 one bit", 400, 0);
        send_bits({1'b0, 9'd150});
        chk_word("R6 stream", 150, 0);

        // R7: after the load falls, shifting leaves the word frozen
        ser_ld = 1'b0;
        step(6);
        send_bits({1'b1, 9'd77});
        chk_word("R7 frozen", 150, 0);
        pulse_ld();
        chk_word("R5 transfer", 77, 1);

        // R4: no shifting while the parallel strobe is low
        par_m = 9'd33; par_ld_n = 1'b0;
        step(4);
        send_bits({1'b0, 9'd99});
        par_ld_n = 1'b1;
        step(6);
        chk_word("R4 par during shift", 33, 0);
        pulse_ld();
        chk_word("R4 shift untouched", 77, 1);

        // R10: master reset drives div_rst, word unchanged
        mreset = 1'b1;
        step(4);
        chk("R10 div_rst high", div_rst, 1);
        chk_word("R10 word kept", 77, 1);
        mreset = 1'b0;
        step(4);
        chk("R10 div_rst low", div_rst, 0);
        chk_word("R10 word after", 77, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule